// File: doc/BRIEF.md
# Iterative Logical Shift-Right Unit

This unit performs a logical right shift of a 32-bit word by moving one bit position per clock. A 5-bit down-counter holds the remaining distance. A one-cycle start pulse begins an operation. The distance comes from a 5-bit immediate field when that field is non-zero. When the field is zero, the distance comes from a 5-bit count taken from a register. The unit then copies the operand into its working register. It shifts that register right by one bit, filling with zero, and decrements the counter until the counter reaches zero. At that point it raises a one-cycle completion pulse.

Latency depends on the data: the completion pulse appears 3 + n clock edges after the edge that samples start, where n is the selected distance. The caller must hold the immediate field, the register count and the operand stable from the start pulse until completion. The unit is meant to sit behind an instruction sequencer, which owns register-file access and decode.

Top module: `srl_iter_unit`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is all zeros.
- R2: When `imm_cnt_i` is non-zero, it alone sets the shift distance, and `reg_cnt_i` has no effect.
- R3: When `imm_cnt_i` is zero, `reg_cnt_i` sets the shift distance.
- R4: The result equals the operand shifted right logically by the selected distance. Zeros enter at bit 31, and each shift step moves bits [31:1] down to [30:0].
- R5: `done_o` is high exactly in the cycle that follows the (3 + n)-th rising edge, counting the edge that samples `start_i` as the first.
- R6: `done_o` is high for exactly one cycle per accepted operation.
- R7: A start pulse is ignored while an operation is in flight, including its completion cycle. Such a pulse produces no extra completion and does not change the result.
- R8: When both counts are zero, `result_o` equals the operand and completion comes 3 edges after start.
- R9: The largest distance, 31, leaves only the original bit 31 in bit 0 and completes after 34 edges.
- R10: `result_o` keeps its value after completion until the copy step of the next accepted operation.
- R11: Each shift step decrements the counter by exactly one, and the counter never decrements from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| imm_cnt_i | input | 5 | Immediate shift distance; zero selects the register count |
| reg_cnt_i | input | 5 | Low bits of the count register |
| operand_i | input | 32 | Word to be shifted |
| result_o | output | 32 | Working register contents; the final value when `done_o` is high |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench checks the case where both counts are zero. A unit that shifted before testing the counter would return a changed word, and one that skipped the copy step would return stale data. It pairs a non-zero immediate with a different register count, and a zero immediate with a non-zero register count. This catches an inverted source select, because the returned distance would differ. It measures completion timing at distances 0, 1, and 31, where an off-by-one in the loop test shows up as a wrong cycle count or a wrong bit position. It also sends start pulses in the middle of an operation and during the completion cycle. A unit that restarted on them would produce a second pulse or overwrite the result.

// File: rtl/srl_iter_pkg.sv
package srl_iter_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIX   = 2'd1,
    ST_COPY  = 2'd2,
    ST_SHIFT = 2'd3
  } sh_state_e;
endpackage

// File: rtl/srl_iter_counter.sv
module srl_iter_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (dec_i) cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_q == $past(ld_val_i)); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !ld_i) |=> cnt_q == $past(cnt_q) - ONE); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0); // R11
endmodule

// File: rtl/srl_iter_datareg.sv
module srl_iter_datareg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] c_q;
  logic [DATA_W-1:0] c_d;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    logic upper;
    if (i == DATA_W - 1) begin : g_top
      assign upper = 1'b0;
    end else begin : g_mid
      assign upper = c_q[i+1];
    end
    assign c_d[i] = load_i ? d_i[i] : (shift_i ? upper : c_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) c_q <= '0;
    else         c_q <= c_d;
  end

  assign q_o = c_q;

  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (c_q[DATA_W-1] == 1'b0) &&
                             (c_q[DATA_W-2:0] == $past(c_q[DATA_W-1:1]))); // R4
  AST_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> c_q == $past(d_i)); // R8
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(c_q)); // R10
endmodule

// File: rtl/srl_iter_ctrl.sv
module srl_iter_ctrl
  import srl_iter_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cnt_zero_i,
  output logic cnt_ld_o,
  output logic cnt_sel_reg_o,
  output logic cnt_dec_o,
  output logic c_load_o,
  output logic c_shift_o,
  output logic done_o
);
  sh_state_e state_q, state_d;

  always_comb begin
    state_d       = state_q;
    cnt_ld_o      = 1'b0;
    cnt_sel_reg_o = 1'b0;
    cnt_dec_o     = 1'b0;
    c_load_o      = 1'b0;
    c_shift_o     = 1'b0;
    done_o        = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        cnt_ld_o = 1'b1;
        state_d  = ST_FIX;
      end
      ST_FIX: begin
        // immediate was zero: fall back to register count
        if (cnt_zero_i) begin
          cnt_ld_o      = 1'b1;
          cnt_sel_reg_o = 1'b1;
        end
        state_d = ST_COPY;
      end
      ST_COPY: begin
        c_load_o = 1'b1;
        state_d  = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (!cnt_zero_i) begin
          cnt_dec_o = 1'b1;
          c_shift_o = 1'b1;
        end else begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_zero_i); // R5
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> state_q != ST_FIX); // R7
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cnt_ld_o, cnt_dec_o}) <= 1); // R11
endmodule

// File: rtl/srl_iter_unit.sv
module srl_iter_unit
  import srl_iter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  imm_cnt_i,
  input  logic [CNT_W-1:0]  reg_cnt_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);
  logic             cnt_ld, cnt_sel_reg, cnt_dec, cnt_zero;
  logic             c_load, c_shift;
  logic [CNT_W-1:0] cnt_val, cnt_ld_val;

  assign cnt_ld_val = cnt_sel_reg ? reg_cnt_i : imm_cnt_i;

  srl_iter_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .cnt_zero_i   (cnt_zero),
    .cnt_ld_o     (cnt_ld),
    .cnt_sel_reg_o(cnt_sel_reg),
    .cnt_dec_o    (cnt_dec),
    .c_load_o     (c_load),
    .c_shift_o    (c_shift),
    .done_o       (done_o)
  );

  srl_iter_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (cnt_ld),
    .ld_val_i(cnt_ld_val),
    .dec_i   (cnt_dec),
    .cnt_o   (cnt_val),
    .zero_o  (cnt_zero)
  );

  srl_iter_datareg #(.DATA_W(DATA_W)) u_c (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (c_load),
    .shift_i(c_shift),
    .d_i    (operand_i),
    .q_o    (result_o)
  );

  AST_SRC_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_ld && !cnt_sel_reg) |=> cnt_val == $past(imm_cnt_i)); // R2
endmodule

// File: tb/srl_iter_unit_tb.sv
module srl_iter_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  imm = '0;
  logic [4:0]  rcnt = '0;
  logic [31:0] opnd = '0;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  srl_iter_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .imm_cnt_i(imm),
    .reg_cnt_i(rcnt), .operand_i(opnd), .result_o(result), .done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // launch one operation; returns completion edge count and result
  task automatic run_op(input logic [4:0] f, input logic [4:0] r, input logic [31:0] d,
                        output int lat, output logic [31:0] res, output int ndone);
    @(negedge clk);
    imm = f; rcnt = r; opnd = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = -1; ndone = 0; res = '0;
    for (int k = 1; k <= 45; k++) begin
      if (done) begin
        ndone++;
        if (lat < 0) begin lat = k; res = result; end
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 result", result, 32'd0);
  endtask

  task automatic t_imm_wins();
    int lat, nd; logic [31:0] res;
    run_op(5'd4, 5'd9, 32'hF000_00F0, lat, res, nd);
    check("R2 result", res, 32'hF000_00F0 >> 4);
    check("R5 latency", lat, 7);
    check("R6 single pulse", nd, 1);
  endtask

  task automatic t_reg_count();
    int lat, nd; logic [31:0] res;
    run_op(5'd0, 5'd12, 32'h8765_4321, lat, res, nd);
    check("R3 result", res, 32'h8765_4321 >> 12);
    check("R5 latency", lat, 15);
  endtask

  task automatic t_zero_both();
    int lat, nd; logic [31:0] res;
    run_op(5'd0, 5'd0, 32'hDEAD_BEEF, lat, res, nd);
    check("R8 result", res, 32'hDEAD_BEEF);
    check("R8 latency", lat, 3);
  endtask

  task automatic t_one_and_max();
    int lat, nd; logic [31:0] res;
    run_op(5'd1, 5'd0, 32'h8000_0001, lat, res, nd);
    check("R4 one step", res, 32'h4000_0000);
    check("R5 one step latency", lat, 4);
    run_op(5'd31, 5'd3, 32'hFFFF_FFFF, lat, res, nd);
    check("R9 max result", res, 32'h0000_0001);
    check("R9 max latency", lat, 34);
    run_op(5'd0, 5'd31, 32'h7FFF_FFFF, lat, res, nd);
    check("R9 reg max result", res, 32'h0000_0000);
  endtask

  task automatic t_busy_ignore();
    int lat, nd; logic [31:0] res;
    @(negedge clk);
    imm = 5'd5; rcnt = 5'd0; opnd = 32'hA5A5_5A5A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = -1; nd = 0; res = '0;
    for (int k = 1; k <= 45; k++) begin
      // pulse start mid-operation (k=2) and in the done cycle (k=8)
      start = (k == 2) || (k == 8);
      if (done) begin nd++; if (lat < 0) begin lat = k; res = result; end end
      @(negedge clk);
    end
    start = 1'b0;
    check("R7 latency kept", lat, 8);
    check("R7 result kept", res, 32'hA5A5_5A5A >> 5);
    check("R7 single done", nd, 1);
    check("R10 result held", result, 32'hA5A5_5A5A >> 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_imm_wins();
    t_reg_count();
    t_zero_both();
    t_one_and_max();
    t_busy_ignore();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule